// File: doc/BRIEF.md
# Clock Rate Calibration Unit

This block turns a stream of oscillator-cycle enables (nominally 32,768 per second) into a one-second tick. It corrects the clock's rate digitally, so the crystal does not need trimming. The divider has two stages. The first stage divides by 256. The second stage counts those stage pulses up to a full second. A signed calibration setting lets the block slightly lengthen or shorten one second in selected minutes. To lengthen a second, it stretches a single first-stage period by half its length, which blanks stage pulses for that long. To shorten a second, it makes a single stage pulse count twice, which splits it.

The correction follows a cycle of 64 minutes, driven by a minute pulse fed back from the calendar counters. The calendar counters are outside this block. A magnitude of N (0 to 31) corrects the first 2N minutes of each cycle, one second in each of those minutes. The sign selects the direction: 1 makes the clock faster, 0 makes it slower. The setting is sampled on each minute pulse, so a change takes effect from the next minute. A separate 512 Hz test output is derived from the uncorrected oscillator enable, so the calibration never moves it. Raising the oscillator stop input clears the dividers and restarts the minute cycle.

Top module: `calib_rate_unit`

## Requirements
- R1: With no correction pending, consecutive `sec_tick` pulses are exactly PRESCALE*SECS oscillator enables apart (32,768 at default parameters). Without `osc_en` the dividers hold.
- R2: With `cal_positive`=0, the second in progress when a corrected minute begins lasts PRESCALE/2 extra enables (+128).
- R3: With `cal_positive`=1, that second lasts PRESCALE fewer enables (−256).
- R4: Minutes are indexed 0..CYCLE_MIN−1. Index 0 is the minute opened by the first `min_tick` after reset or stop, and the index wraps to 0 after CYCLE_MIN−1. A minute is corrected exactly when its index is below 2*`cal_mag`.
- R5: At most one second is altered per minute; all other seconds in a corrected minute follow R1.
- R6: `cal_mag` and `cal_positive` are sampled only on `min_tick`; changing them mid-minute does not affect the current minute.
- R7: `ftest_out` toggles once every FT_HALF enables (32 at default, giving 512 Hz), regardless of the calibration setting.
- R8: While `osc_stop` is high, the dividers, the test output and the minute cycle are cleared. The next `min_tick` after release opens minute 0.
- R9: After reset, `sec_tick` and `ftest_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| osc_stop | input | 1 | Oscillator stop level; clears dividers and minute cycle |
| cal_mag | input | MAG_W | Calibration magnitude N |
| cal_positive | input | 1 | 1 = speed up, 0 = slow down |
| min_tick | input | 1 | Minute pulse from the calendar |
| sec_tick | output | 1 | One-cycle pulse per corrected second (registered) |
| ftest_out | output | 1 | 512 Hz square wave from the uncorrected oscillator |

## Verification
If the minute index is off, correction shows up in the wrong minutes. For example, minute 2N would be corrected, or the first minute after the wrap would not be. A wrong correction state shows up in the length of the first second measured after a minute pulse, which is one second later at most. If the pending flag fails to clear, a second correction appears in the next second of the same minute. If the sampled setting is wrong, a mid-minute change alters the current minute. Any drift in the test divider shows as a phase error in `ftest_out` at the next second boundary.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_SLOW = 2'd1,
    CORR_FAST = 2'd2
  } corr_e;
endpackage

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
  parameter int PRESCALE = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic osc_en,
  input  logic stretch,
  output logic stage_pulse,
  output logic stretched
);
  localparam int HALF = PRESCALE / 2;
  localparam int LONG = PRESCALE + HALF;
  localparam int CW   = $clog2(LONG);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit       = stretch ? CW'(LONG - 1) : CW'(PRESCALE - 1);
  assign stage_pulse = osc_en && (cnt >= limit);
  assign stretched   = stage_pulse && stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (stage_pulse) cnt <= '0;
    else if (osc_en)      cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LONG - 1));
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/rate_postscaler.sv
module rate_postscaler #(
  parameter int SECS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stage_pulse,
  input  logic split,
  output logic sec_pulse,
  output logic split_used
);
  localparam int PW = $clog2(SECS + 2) + 1;

  logic [PW-1:0] cnt;
  logic [PW-1:0] sum;

  assign sum        = cnt + (split ? PW'(2) : PW'(1));
  assign sec_pulse  = stage_pulse && (sum >= PW'(SECS));
  assign split_used = stage_pulse && split;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (sec_pulse)  cnt <= sum - PW'(SECS);
    else if (stage_pulse) cnt <= sum;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < PW'(SECS));
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import calib_pkg::*;
#(
  parameter int CYCLE_MIN = 64,
  parameter int MAG_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             min_tick,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  input  logic             consume,
  output corr_e            corr
);
  localparam int MIW = $clog2(CYCLE_MIN);
  localparam int SW  = ((MAG_W + 1 > MIW) ? MAG_W + 1 : MIW) + 1;

  logic [MIW-1:0]   mi;
  logic [MIW-1:0]   nxt;
  logic [MAG_W-1:0] mag_l;
  logic             pos_l;
  logic             pend;
  logic             hit;

  assign nxt = (mi == MIW'(CYCLE_MIN - 1)) ? '0 : mi + 1'b1;
  assign hit = SW'(nxt) < SW'({cal_mag, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mi    <= MIW'(CYCLE_MIN - 1);
      mag_l <= '0;
      pos_l <= 1'b0;
      pend  <= 1'b0;
    end else if (stop) begin
      mi    <= MIW'(CYCLE_MIN - 1);
      pend  <= 1'b0;
    end else if (min_tick) begin
      mi    <= nxt;
      mag_l <= cal_mag;
      pos_l <= cal_pos;
      pend  <= hit;
    end else if (consume) begin
      pend  <= 1'b0;
    end
  end

  always_comb begin
    if (!pend)      corr = CORR_NONE;
    else if (pos_l) corr = CORR_FAST;
    else            corr = CORR_SLOW;
  end

  p_arm_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (SW'(mi) < SW'({mag_l, 1'b0})));
  p_single_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !min_tick) |=> !pend);
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!pend && mi == MIW'(CYCLE_MIN - 1)));
endmodule

// File: rtl/ftest_divider.sv
module ftest_divider #(
  parameter int FT_HALF = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic osc_en,
  output logic ft_out
);
  localparam int FW = $clog2(FT_HALF) + 1;
  logic [FW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ft_out <= 1'b0;
    end else if (clr) begin
      cnt <= '0; ft_out <= 1'b0;
    end else if (osc_en) begin
      if (cnt == FW'(FT_HALF - 1)) begin
        cnt <= '0; ft_out <= ~ft_out;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_ft_needs_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ft_out != $past(ft_out)) |-> ($past(osc_en) || $past(clr)));
endmodule

// File: rtl/calib_rate_unit.sv
module calib_rate_unit
  import calib_pkg::*;
#(
  parameter int PRESCALE  = 256,
  parameter int SECS      = 128,
  parameter int FT_HALF   = 32,
  parameter int CYCLE_MIN = 64,
  parameter int MAG_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             osc_stop,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_positive,
  input  logic             min_tick,
  output logic             sec_tick,
  output logic             ftest_out
);
  corr_e corr;
  logic  stage_pulse, stretched, sec_pulse, split_used;

  cal_sequencer #(.CYCLE_MIN(CYCLE_MIN), .MAG_W(MAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop(osc_stop), .min_tick(min_tick),
    .cal_mag(cal_mag), .cal_pos(cal_positive),
    .consume(stretched || split_used), .corr(corr));

  rate_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(osc_stop), .osc_en(osc_en),
    .stretch(corr == CORR_SLOW), .stage_pulse(stage_pulse),
    .stretched(stretched));

  rate_postscaler #(.SECS(SECS)) u_post (
    .clk(clk), .rst_n(rst_n), .clr(osc_stop), .stage_pulse(stage_pulse),
    .split(corr == CORR_FAST), .sec_pulse(sec_pulse),
    .split_used(split_used));

  ftest_divider #(.FT_HALF(FT_HALF)) u_ft (
    .clk(clk), .rst_n(rst_n), .clr(osc_stop), .osc_en(osc_en),
    .ft_out(ftest_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sec_tick <= 1'b0;
    else if (osc_stop) sec_tick <= 1'b0;
    else               sec_tick <= sec_pulse;
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> !sec_tick);
endmodule

// File: tb/calib_rate_unit_test.sv
module calib_rate_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRE  = 16;
  localparam int SECS = 8;
  localparam int FTH  = 4;
  localparam int CYC  = 64;
  localparam int NOM  = PRE * SECS;
  localparam int SPM  = 3;

  logic clk = 0, rst_n = 0, osc_en = 0, osc_stop = 0, cal_positive = 0, min_tick = 0;
  logic [4:0] cal_mag = '0;
  logic sec_tick, ftest_out;

  int checks = 0, fails = 0, cycles = 0;
  int tot = 0;
  int m_b = -1;
  int mag_l = 0;
  bit pos_l = 0;
  bit first_sec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calib_rate_unit #(.PRESCALE(PRE), .SECS(SECS), .FT_HALF(FTH), .CYCLE_MIN(CYC), .MAG_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_stop(osc_stop),
    .cal_mag(cal_mag), .cal_positive(cal_positive), .min_tick(min_tick),
    .sec_tick(sec_tick), .ftest_out(ftest_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input bit first, input int m, input int mag, input bit pos);
    if (first && m >= 0 && m < 2 * mag) return pos ? NOM - PRE : NOM + PRE / 2;
    return NOM;
  endfunction

  task automatic run_second(output int len);
    bit done;
    len = 0;
    done = 0;
    while (!done && len < 4 * NOM) begin
      @(negedge clk);
      min_tick = 0;
      if (osc_en) begin len++; tot++; end
      done = sec_tick;
      osc_en = ($urandom % 4) != 0;
    end
  endtask

  task automatic do_second(input string req);
    int len, e;
    e = exp_len(first_sec, m_b, mag_l, pos_l);
    run_second(len);
    if (e == NOM) check(len == e, first_sec ? {req, "/R5"} : "R1/R5", len, e);
    else          check(len == e, pos_l ? "R3" : "R2", len, e);
    check(ftest_out == ((tot / FTH) % 2), "R7", ftest_out, (tot / FTH) % 2);
    first_sec = 0;
  endtask

  task automatic minute_edge();
    min_tick = 1;
    m_b = (m_b + 1) % CYC;
    mag_l = cal_mag;
    pos_l = cal_positive;
    first_sec = 1;
  endtask

  task automatic run_minutes(input int n, input bit rnd_cal, input string req);
    for (int i = 0; i < n; i++) begin
      minute_edge();
      for (int s = 0; s < SPM; s++) begin
        do_second(req);
        if (rnd_cal && s == 0) begin
          cal_mag = 5'($urandom);
          cal_positive = 1'($urandom);
        end
      end
    end
  endtask

  task automatic do_stop();
    osc_en = 0;
    osc_stop = 1;
    repeat (3) @(negedge clk);
    check(sec_tick == 0 && ftest_out == 0, "R8", {sec_tick, ftest_out}, 0);
    osc_stop = 0;
    tot = 0;
    m_b = -1;
    first_sec = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(sec_tick == 0, "R9", sec_tick, 0);
    check(ftest_out == 0, "R9", ftest_out, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(sec_tick == 0, "R1", sec_tick, 0);
    // first second after reset: nominal
    do_second("R1");
    // slow correction, magnitude 3: minutes 0..5 corrected, wrap covered
    cal_mag = 5'd3; cal_positive = 0;
    run_minutes(70, 0, "R4");
    // stop, then fast correction with full magnitude 31 (62 minutes)
    do_stop();
    cal_mag = 5'd31; cal_positive = 1;
    do_second("R8");
    run_minutes(66, 0, "R4");
    // magnitude 1 positive after stop: only minutes 0 and 1
    do_stop();
    cal_mag = 5'd1; cal_positive = 1;
    do_second("R8");
    run_minutes(4, 0, "R4");
    // mid-minute random changes: latched value must govern (R6)
    run_minutes(40, 1, "R6");
    // magnitude zero: no correction at all
    cal_mag = 5'd0; cal_positive = 0;
    run_minutes(4, 0, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule